// File: doc/BRIEF.md
# Sniff Trace Record Writer

This block sits between two frame decoders of a passive radio sniffer and a byte-wide trace memory. One decoder recovers commands sent by the reader. The other recovers responses sent by the card. Each decoder raises a done level when it holds a complete frame. It then presents a phase offset, a 32-bit parity word and a length, and it returns payload bytes combinationally for an index the writer drives. The writer turns every such frame into a record in a linear trace area. It then re-arms the decoders so they look for the next frame.

A capture begins with a start pulse. The writer first floods the trace area with a known filler byte and then waits for frames. A free-running sample counter, cleared at start and advanced on each sample strobe, provides timestamps. Each record is a corrected timestamp, the parity word, a length byte and the payload, laid out back to back from address 0. Capture ends when the write pointer passes a limit after a record, or at once when abort is asserted.

Top module: `trace_record_writer`

## Requirements
- R1: After reset, capture_active is 0, mem_we is 0 and neither re-arm output is high.
- R2: A start pulse while idle raises cmd_rearm and rsp_rearm in that same cycle. It then writes 8'h44 to addresses 0 to FILL_BYTES-1, one byte per cycle, and then waits for frames with capture_active high.
- R3: The record timestamp equals the number of sample strobes seen since start, minus the reporting decoder's phase offset, taken in the cycle the frame is accepted. It is written to record bytes 0 to 3, least significant byte first.
- R4: In a response record, bit 7 of record byte 3 is forced to 1. In a command record, byte 3 is written unchanged (bit 7 is 0 for timestamps below 2^31).
- R5: Record bytes 4 to 7 hold the parity word, least significant byte first. Byte 8 is the length. Bytes 9 onward are payload bytes 0 to len-1. The payload is read through the decoder's index and data ports. The first record starts at address 0 and each later record follows the previous one with no gap.
- R6: When a command record is complete, cmd_rearm and rsp_rearm pulse together for one cycle, so a response decoder falsely triggered by the command is cleared.
- R7: If both decoders report done in the same cycle, the command is logged first. In that case rsp_rearm stays low after the command record, the held response is logged next, and rsp_rearm pulses only after the response record.
- R8: After a record whose end leaves the write pointer above TRACE_LIMIT, capture_active falls. No further writes or re-arms occur until the next start.
- R9: Abort ends capture at once: mem_we is 0 in the abort cycle, capture_active is 0 in the next cycle, and nothing more is written.
- R10: A frame of length 0 produces a 9-byte record with length byte 0 and no payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a capture (fill, then record) |
| abort | input | 1 | End the capture immediately |
| sample_stb | input | 1 | Advances the timestamp counter |
| capture_active | output | 1 | High from start until the capture ends |
| cmd_done | input | 1 | Command decoder holds a frame |
| cmd_phase | input | PHASE_W | Command decoder sync phase offset |
| cmd_parity | input | 32 | Command parity word |
| cmd_len | input | 8 | Command payload length |
| cmd_rd_idx | output | 8 | Command payload read index |
| cmd_rd_data | input | 8 | Command payload byte at cmd_rd_idx |
| cmd_rearm | output | 1 | Return command decoder to unsynchronised |
| rsp_done | input | 1 | Response decoder holds a frame |
| rsp_phase | input | PHASE_W | Response decoder sync phase offset |
| rsp_parity | input | 32 | Response parity word |
| rsp_len | input | 8 | Response payload length |
| rsp_rd_idx | output | 8 | Response payload read index |
| rsp_rd_data | input | 8 | Response payload byte at rsp_rd_idx |
| rsp_rearm | output | 1 | Return response decoder to unsynchronised |
| mem_we | output | 1 | Trace memory byte write enable |
| mem_addr | output | ADDR_W | Trace memory byte address |
| mem_wdata | output | 8 | Trace memory write data |

## Verification
The bench targets the points where records meet.

- A collision of both decoders in one cycle. A writer that re-armed the response decoder after the command record would lose the pending response, so the second record would be missing.
- The fill-to-record handover and back-to-back records. An off-by-one in the pointer would leave a gap or overlap one record with the next.
- A zero-length response. A design that did not special-case it would read a bogus payload byte.
- The limit crossing. A design that compared with the wrong sense would keep logging.
- An abort in the middle of a header. A design that let the current write through, or that re-armed a decoder, would show one more byte or one more pulse.

// File: rtl/trace_record_writer.sv
module trace_record_writer #(
  parameter int ADDR_W      = 12,
  parameter int FILL_BYTES  = 3032,
  parameter int TRACE_LIMIT = 3000,
  parameter int PHASE_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               sample_stb,
  output logic               capture_active,
  input  logic               cmd_done,
  input  logic [PHASE_W-1:0] cmd_phase,
  input  logic [31:0]        cmd_parity,
  input  logic [7:0]         cmd_len,
  output logic [7:0]         cmd_rd_idx,
  input  logic [7:0]         cmd_rd_data,
  output logic               cmd_rearm,
  input  logic               rsp_done,
  input  logic [PHASE_W-1:0] rsp_phase,
  input  logic [31:0]        rsp_parity,
  input  logic [7:0]         rsp_len,
  output logic [7:0]         rsp_rd_idx,
  input  logic [7:0]         rsp_rd_data,
  output logic               rsp_rearm,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata
);

  localparam logic [ADDR_W-1:0] FILL_LAST = ADDR_W'(FILL_BYTES - 1);
  localparam logic [ADDR_W-1:0] LIMIT     = ADDR_W'(TRACE_LIMIT);
  localparam logic [7:0]        HDR_LAST  = 8'd8;
  localparam logic [7:0]        FILLER    = 8'h44;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_WAIT, S_HDR, S_PAY, S_END} state_t;

  state_t            st;
  logic [ADDR_W-1:0] ptr;
  logic [31:0]       cnt, ts, par;
  logic [7:0]        idx, len;
  logic              sel_rsp, rsp_pend;
  logic              go, take_rsp;
  logic [7:0]        hdr_byte, pay_byte;

  assign go             = (st == S_IDLE) && start && !abort;
  assign take_rsp       = rsp_done && (rsp_pend || !cmd_done);
  assign capture_active = (st != S_IDLE);
  assign cmd_rearm      = go || ((st == S_END) && !sel_rsp);
  assign rsp_rearm      = go || ((st == S_END) && (sel_rsp || !rsp_pend));
  assign cmd_rd_idx     = idx;
  assign rsp_rd_idx     = idx;
  assign pay_byte       = sel_rsp ? rsp_rd_data : cmd_rd_data;
  assign mem_addr       = ptr;
  assign mem_we         = !abort && (st == S_FILL || st == S_HDR || st == S_PAY);

  always_comb begin
    case (idx[3:0])
      4'd0:    hdr_byte = ts[7:0];
      4'd1:    hdr_byte = ts[15:8];
      4'd2:    hdr_byte = ts[23:16];
      4'd3:    hdr_byte = {ts[31] | sel_rsp, ts[30:24]};
      4'd4:    hdr_byte = par[7:0];
      4'd5:    hdr_byte = par[15:8];
      4'd6:    hdr_byte = par[23:16];
      4'd7:    hdr_byte = par[31:24];
      default: hdr_byte = len;
    endcase
  end

  always_comb begin
    case (st)
      S_FILL:  mem_wdata = FILLER;
      S_HDR:   mem_wdata = hdr_byte;
      S_PAY:   mem_wdata = pay_byte;
      default: mem_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      cnt      <= '0;
      ts       <= '0;
      par      <= '0;
      len      <= '0;
      idx      <= '0;
      sel_rsp  <= 1'b0;
      rsp_pend <= 1'b0;
    end else if (abort) begin
      st <= S_IDLE;
    end else begin
      if (st != S_IDLE && sample_stb) cnt <= cnt + 32'd1;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_FILL;
          ptr      <= '0;
          cnt      <= '0;
          rsp_pend <= 1'b0;
        end
        S_FILL: begin
          ptr <= ptr + 1'b1;
          if (ptr == FILL_LAST) begin
            ptr <= '0;
            st  <= S_WAIT;
          end
        end
        S_WAIT: if (cmd_done || rsp_done) begin
          sel_rsp <= take_rsp;
          idx     <= '0;
          st      <= S_HDR;
          if (take_rsp) begin
            ts       <= cnt - 32'(rsp_phase);
            par      <= rsp_parity;
            len      <= rsp_len;
            rsp_pend <= 1'b0;
          end else begin
            ts       <= cnt - 32'(cmd_phase);
            par      <= cmd_parity;
            len      <= cmd_len;
            rsp_pend <= rsp_done;
          end
        end
        S_HDR: begin
          ptr <= ptr + 1'b1;
          idx <= idx + 8'd1;
          if (idx == HDR_LAST) begin
            idx <= '0;
            st  <= (len == 8'd0) ? S_END : S_PAY;
          end
        end
        S_PAY: begin
          ptr <= ptr + 1'b1;
          idx <= idx + 8'd1;
          if (idx == len - 8'd1) st <= S_END;
        end
        S_END: st <= (ptr > LIMIT) ? S_IDLE : S_WAIT;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trace_record_writer_chk.sv
module trace_record_writer_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              capture_active,
  input logic              cmd_rearm,
  input logic              rsp_rearm,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata
);

  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !capture_active) |-> (cmd_rearm && rsp_rearm)); // R2

  AST_START_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !capture_active) |=>
      (capture_active && (abort || (mem_we && mem_wdata == 8'h44)))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5

  AST_REARM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rearm || rsp_rearm) |-> !mem_we); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_active |-> !mem_we); // R8

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !mem_we); // R9

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !capture_active); // R9

endmodule

bind trace_record_writer trace_record_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .capture_active(capture_active), .cmd_rearm(cmd_rearm), .rsp_rearm(rsp_rearm),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_trace_record_writer.sv
`timescale 1ns/1ps
module sim_trace_record_writer;
  localparam int AW = 12;
  localparam int FILLN = 48;
  localparam int LIM = 40;

  logic clk = 0, rst_n = 0, start = 0, abort = 0, sample_stb = 0;
  logic cmd_done = 0, rsp_done = 0;
  logic [3:0] cmd_phase = 0, rsp_phase = 0;
  logic [31:0] cmd_parity = 0, rsp_parity = 0;
  logic [7:0] cmd_len = 0, rsp_len = 0;
  logic [7:0] cmd_rd_idx, rsp_rd_idx, cmd_rd_data, rsp_rd_data;
  logic capture_active, cmd_rearm, rsp_rearm, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] cmd_buf [0:15];
  logic [7:0] rsp_buf [0:15];
  logic [7:0] tmem [0:(1<<AW)-1];
  int checks = 0, errors = 0, wcount = 0, ccnt = 0, rcnt = 0;

  always #5 clk = ~clk;

  assign cmd_rd_data = cmd_buf[cmd_rd_idx[3:0]];
  assign rsp_rd_data = rsp_buf[rsp_rd_idx[3:0]];

  trace_record_writer #(.ADDR_W(AW), .FILL_BYTES(FILLN), .TRACE_LIMIT(LIM), .PHASE_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sample_stb(sample_stb),
    .capture_active(capture_active),
    .cmd_done(cmd_done), .cmd_phase(cmd_phase), .cmd_parity(cmd_parity), .cmd_len(cmd_len),
    .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data), .cmd_rearm(cmd_rearm),
    .rsp_done(rsp_done), .rsp_phase(rsp_phase), .rsp_parity(rsp_parity), .rsp_len(rsp_len),
    .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data), .rsp_rearm(rsp_rearm),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    if (mem_we) begin
      tmem[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (cmd_rearm) ccnt <= ccnt + 1;
    if (rsp_rearm) rcnt <= rcnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic service(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_rearm) cmd_done = 0;
      if (rsp_rearm) rsp_done = 0;
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sample_stb = 1;
      @(negedge clk) sample_stb = 0;
    end
  endtask

  task automatic chk_hdr(input string req, input int base, input logic [31:0] ts,
                         input logic [31:0] par, input int len);
    for (int i = 0; i < 4; i++) chk(req, tmem[base+i], int'(ts[8*i +: 8]));
    for (int i = 0; i < 4; i++) chk("R5 parity", tmem[base+4+i], int'(par[8*i +: 8]));
    chk("R5 length", tmem[base+8], len);
  endtask

  task automatic t_reset;
    chk("R1 capture_active", capture_active, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 rearm", {cmd_rearm, rsp_rearm}, 0);
  endtask

  task automatic t_start_fill;
    int bad = 0;
    int c0 = ccnt, r0 = rcnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 cmd_rearm at start", ccnt - c0, 1);
    chk("R2 rsp_rearm at start", rcnt - r0, 1);
    service(FILLN + 5);
    chk("R2 fill write count", wcount, FILLN);
    for (int i = 0; i < FILLN; i++) if (tmem[i] !== 8'h44) bad++;
    chk("R2 fill bytes", bad, 0);
    chk("R2 active after fill", capture_active, 1);
  endtask

  task automatic t_cmd_record;
    int c0, r0;
    strobes(10);
    cmd_phase = 3; cmd_parity = 32'h0A0B0C0D; cmd_len = 3;
    cmd_buf[0] = 8'h11; cmd_buf[1] = 8'h22; cmd_buf[2] = 8'h33;
    c0 = ccnt; r0 = rcnt;
    @(negedge clk) cmd_done = 1;
    service(20);
    chk_hdr("R3 cmd timestamp", 0, 32'd7, 32'h0A0B0C0D, 3);
    chk("R4 cmd dir bit clear", tmem[3] & 8'h80, 0);
    chk("R5 payload0", tmem[9], 8'h11);
    chk("R5 payload2", tmem[11], 8'h33);
    chk("R6 cmd rearm", ccnt - c0, 1);
    chk("R6 rsp rearm after cmd", rcnt - r0, 1);
  endtask

  task automatic t_rsp_record;
    strobes(5);
    rsp_phase = 2; rsp_parity = 32'h01020304; rsp_len = 2;
    rsp_buf[0] = 8'hA5; rsp_buf[1] = 8'h5A;
    @(negedge clk) rsp_done = 1;
    service(20);
    chk_hdr("R3 rsp timestamp", 12, 32'h8000000D, 32'h01020304, 2);
    chk("R4 rsp dir bit set", tmem[15], 8'h80);
    chk("R5 rsp payload", {tmem[21], tmem[22]}, 16'hA55A);
  endtask

  task automatic t_both_limit;
    int c0 = ccnt, r0 = rcnt, w0;
    cmd_phase = 0; cmd_parity = 32'hFFEEDDCC; cmd_len = 1; cmd_buf[0] = 8'h77;
    rsp_phase = 1; rsp_parity = 32'h00000001; rsp_len = 0;
    @(negedge clk) begin cmd_done = 1; rsp_done = 1; end
    service(40);
    chk_hdr("R7 cmd first", 23, 32'd15, 32'hFFEEDDCC, 1);
    chk("R7 cmd payload", tmem[32], 8'h77);
    chk_hdr("R7 rsp second", 33, 32'h8000000E, 32'h1, 0);
    chk("R10 no payload byte written", tmem[42], 8'h44);
    chk("R7 cmd rearm once", ccnt - c0, 1);
    chk("R7 rsp rearm once", rcnt - r0, 1);
    chk("R8 capture stopped", capture_active, 0);
    w0 = wcount; c0 = ccnt;
    @(negedge clk) cmd_done = 1;
    service(20);
    cmd_done = 0;
    chk("R8 no writes after stop", wcount - w0, 0);
    chk("R8 no rearm after stop", ccnt - c0, 0);
  endtask

  task automatic t_abort;
    int w0, c0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    service(FILLN + 5);
    cmd_len = 5;
    @(negedge clk) cmd_done = 1;
    repeat (3) @(negedge clk);
    abort = 1;
    w0 = wcount; c0 = ccnt;
    @(negedge clk) abort = 0;
    chk("R9 inactive after abort", capture_active, 0);
    chk("R9 no write in abort cycle", wcount - w0, 0);
    repeat (10) @(negedge clk);
    cmd_done = 0;
    chk("R9 no writes later", wcount - w0, 0);
    chk("R9 no rearm", ccnt - c0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_start_fill();
    t_cmd_record();
    t_rsp_record();
    t_both_limit();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule